// File: doc/BRIEF.md
# Multi-Mode Character Raster Generator

This block produces a 640x480 monitor raster from a 25.175 MHz pixel clock. It emits active-low horizontal and vertical sync, a blank flag and a single monochrome pixel bit. Each pixel is drawn by looking up a character code in video memory and then a glyph byte in a font memory. Both memories are outside the block and answer one clock after they are addressed.

Three text layouts are available. Two narrow layouts, 64 and 32 columns by 16 rows, use 8x12 cells shown in a 512x384 window. The window is centred in the raster and surrounded by a black border. In the 32-column layout every glyph pixel lasts two clocks. The wide layout, 80 columns by 24 rows, uses 8x10 cells and fills the whole visible area. In all layouts each glyph row is repeated on two consecutive scan lines. Each character owns 16 rows in the font memory, and only the leading 10 or 12 of them are used.

Top module: `vga_text_gen`

## Requirements
- R1: `hsync_n` is low for 96 clocks in every 800-clock line, starting at horizontal position 656 (640 visible + 16 front porch), and is high otherwise.
- R2: `vsync_n` is low for 2 whole lines in every 525-line frame, on lines 490 and 491, and is high otherwise.
- R3: `blank` is high whenever the position is outside the 640x480 visible area, and `pixel` is 0 whenever `blank` is high.
- R4: With `mode` = 2'b00 (64 columns), the character window covers horizontal positions 64..575 and lines 48..431, and everything else in the visible area is black. Cells are 8 clocks wide, and the video address is row*64 + column.
- R5: With `mode` = 2'b01 (32 columns), the window is the same as in R4, each glyph bit is output for 2 clocks, cells are 16 clocks wide, and the video address is row*32 + column.
- R6: With `mode` = 2'b10 or 2'b11 (80 columns), the window is the full 640x480 area, cells are 8 clocks wide and 10 glyph rows tall, and the video address is row*80 + column.
- R7: Each glyph row appears on two consecutive scan lines. Narrow modes use glyph rows 0..11 and the wide mode uses rows 0..9.
- R8: The font address is {character code, glyph row[3:0]}. Bit 7 of the font byte is the leftmost pixel of the cell.
- R9: Both memories are read with one clock of latency. All four raster outputs of raster position p appear 5 clocks after that position is counted, where position 0 is the first clock after reset is released.
- R10: `mode` is sampled during reset and on the last clock of each frame. A change in the middle of a frame takes effect only with the next frame.
- R11: While reset is asserted and until the pipeline fills, `hsync_n` = 1, `vsync_n` = 1, `blank` = 1 and `pixel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Layout select: 00 = 64 columns, 01 = 32 columns, 1x = 80 columns |
| vram_addr | output | 11 | Character cell address into video memory |
| vram_data | input | 8 | Character code, one clock after `vram_addr` |
| font_addr | output | 12 | Code and glyph row into font memory |
| font_data | input | 8 | Glyph byte, one clock after `font_addr` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| pixel | output | 1 | Monochrome pixel, 1 = lit |

## Verification
Every output of a raster position is due exactly 5 clocks after the position counter reaches it. That is one register for the video address, one clock of video memory, one register for the font address, one clock of font memory and the output register. The bench counts rising edges since reset release and samples on the falling edge. After edge m it compares against the position m-5, and it expects idle values for the first four edges. The layout is tied to the frame: the bench records `mode` at the edge that closes each frame and uses that record for the whole next frame. This is how a change in the middle of a frame is checked against the old layout. Memories are modelled as one-clock functions of the address, so the expected glyph bit comes from the same code and font functions.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int GLYPH_W   = 8;
    localparam int GROW_BITS = 4;

    typedef enum logic [1:0] {
        VM_COL64 = 2'd0,
        VM_COL32 = 2'd1,
        VM_COL80 = 2'd2
    } vmode_e;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic blank;
    } sync_t;

    typedef struct packed {
        sync_t                sy;
        logic                 win;
        logic [2:0]           bsel;
        logic [GROW_BITS-1:0] grow;
    } side_t;

    localparam sync_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, blank: 1'b1};
    localparam side_t SIDE_IDLE = '{sy: SYNC_IDLE, win: 1'b0, bsel: 3'd0, grow: '0};

    function automatic vmode_e decode_mode(input logic [1:0] sel);
        if (sel[1])      return VM_COL80;
        else if (sel[0]) return VM_COL32;
        else             return VM_COL64;
    endfunction

endpackage

// File: rtl/vtg_raster.sv
module vtg_raster
    import vtg_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic          line_end,
    output logic          frame_end,
    output sync_t         raw
);
    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
    localparam logic [HW-1:0] H_VIS_T = HW'(H_VIS);
    localparam logic [VW-1:0] V_VIS_T = VW'(V_VIS);
    localparam logic [HW-1:0] HS_LO = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_HI = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_LO = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_HI = VW'(V_VIS + V_FP + V_SYNC);

    assign line_end  = (h == H_LAST);
    assign frame_end = line_end && (v == V_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
            v <= '0;
        end else if (line_end) begin
            h <= '0;
            v <= frame_end ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end

    always_comb begin
        raw.hs_n  = !((h >= HS_LO) && (h < HS_HI));
        raw.vs_n  = !((v >= VS_LO) && (v < VS_HI));
        raw.blank = !((h < H_VIS_T) && (v < V_VIS_T));
    end
endmodule

// File: rtl/vtg_rowtrack.sv
module vtg_rowtrack
    import vtg_pkg::*;
#(
    parameter int V_VIS    = 480,
    parameter int WIN_H    = 384,
    parameter int CELL_H_N = 12,
    parameter int CELL_H_W = 10,
    parameter int NCOL_64  = 64,
    parameter int NCOL_32  = 32,
    parameter int NCOL_80  = 80,
    parameter int VW       = 10,
    parameter int AW       = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VW-1:0]        v,
    input  logic                 line_end,
    input  logic                 frame_end,
    input  vmode_e               mode,
    output logic                 v_in,
    output logic [AW-1:0]        row_base,
    output logic [GROW_BITS-1:0] grow
);
    localparam logic [VW-1:0] VOFF  = VW'((V_VIS - WIN_H) / 2);
    localparam logic [VW-1:0] VEND  = VW'((V_VIS - WIN_H) / 2 + WIN_H);
    localparam logic [VW-1:0] V_TOP = VW'(V_VIS);

    logic                 repeat_line;
    logic [GROW_BITS-1:0] last_grow;
    logic [AW-1:0]        ncols;

    always_comb begin
        unique case (mode)
            VM_COL80: begin
                v_in      = (v < V_TOP);
                last_grow = GROW_BITS'(CELL_H_W - 1);
                ncols     = AW'(NCOL_80);
            end
            VM_COL32: begin
                v_in      = (v >= VOFF) && (v < VEND);
                last_grow = GROW_BITS'(CELL_H_N - 1);
                ncols     = AW'(NCOL_32);
            end
            default: begin
                v_in      = (v >= VOFF) && (v < VEND);
                last_grow = GROW_BITS'(CELL_H_N - 1);
                ncols     = AW'(NCOL_64);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            repeat_line <= 1'b0;
            grow        <= '0;
            row_base    <= '0;
        end else if (line_end && v_in) begin
            if (repeat_line) begin
                repeat_line <= 1'b0;
                if (grow == last_grow) begin
                    grow     <= '0;
                    row_base <= row_base + ncols;
                end else begin
                    grow <= grow + 1'b1;
                end
            end else begin
                repeat_line <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtg_fetch.sv
module vtg_fetch
    import vtg_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int WIN_W  = 512,
    parameter int HW     = 10,
    parameter int AW     = 11,
    parameter int CODE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HW-1:0]        h,
    input  vmode_e               mode,
    input  logic                 v_in,
    input  logic [AW-1:0]        row_base,
    input  logic [GROW_BITS-1:0] grow,
    input  sync_t                raw,
    input  logic [CODE_W-1:0]    vram_data,
    input  logic [GLYPH_W-1:0]   font_data,
    output logic [AW-1:0]        vram_addr,
    output logic [CODE_W+GROW_BITS-1:0] font_addr,
    output logic                 hsync_n,
    output logic                 vsync_n,
    output logic                 blank,
    output logic                 pixel
);
    localparam int STAGES = 4;
    localparam logic [HW-1:0] HOFF    = HW'((H_VIS - WIN_W) / 2);
    localparam logic [HW-1:0] HEND    = HW'((H_VIS - WIN_W) / 2 + WIN_W);
    localparam logic [HW-1:0] H_VIS_T = HW'(H_VIS);

    logic          h_in;
    logic [HW-1:0] x;
    logic [HW-1:0] col;
    side_t         cur;
    side_t [STAGES:1] pipe;

    always_comb begin
        if (mode == VM_COL80) begin
            h_in = (h < H_VIS_T);
            x    = h;
        end else begin
            h_in = (h >= HOFF) && (h < HEND);
            x    = h - HOFF;
        end
        if (mode == VM_COL32) begin
            col      = x >> 4;
            cur.bsel = x[3:1];
        end else begin
            col      = x >> 3;
            cur.bsel = x[2:0];
        end
        cur.sy   = raw;
        cur.win  = h_in && v_in;
        cur.grow = grow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vram_addr <= '0;
            font_addr <= '0;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= SIDE_IDLE;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            blank   <= 1'b1;
            pixel   <= 1'b0;
        end else begin
            vram_addr <= cur.win ? row_base + AW'(col) : '0;
            pipe[1]   <= cur;
            for (int i = 2; i <= STAGES; i++) pipe[i] <= pipe[i-1];
            font_addr <= {vram_data, pipe[2].grow};
            hsync_n   <= pipe[STAGES].sy.hs_n;
            vsync_n   <= pipe[STAGES].sy.vs_n;
            blank     <= pipe[STAGES].sy.blank;
            pixel     <= pipe[STAGES].win && font_data[3'd7 - pipe[STAGES].bsel];
        end
    end
endmodule

// File: rtl/vga_text_gen.sv
module vga_text_gen
    import vtg_pkg::*;
#(
    parameter int H_VIS    = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int WIN_W    = 512,
    parameter int WIN_H    = 384,
    parameter int CELL_H_N = 12,
    parameter int CELL_H_W = 10,
    parameter int CODE_W   = 8,
    parameter int AW       = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  mode,
    output logic [AW-1:0]               vram_addr,
    input  logic [CODE_W-1:0]           vram_data,
    output logic [CODE_W+GROW_BITS-1:0] font_addr,
    input  logic [GLYPH_W-1:0]          font_data,
    output logic                        hsync_n,
    output logic                        vsync_n,
    output logic                        blank,
    output logic                        pixel
);
    localparam int H_TOT   = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT   = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOT);
    localparam int VW      = $clog2(V_TOT);
    localparam int NCOL_64 = WIN_W / GLYPH_W;
    localparam int NCOL_32 = WIN_W / (2 * GLYPH_W);
    localparam int NCOL_80 = H_VIS / GLYPH_W;

    logic [HW-1:0]        h;
    logic [VW-1:0]        v;
    logic                 line_end;
    logic                 frame_end;
    sync_t                raw;
    vmode_e               mode_q;
    logic                 v_in;
    logic [AW-1:0]        row_base;
    logic [GROW_BITS-1:0] grow;

    always_ff @(posedge clk) begin
        if (rst || frame_end) mode_q <= decode_mode(mode);
    end

    vtg_raster #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_raster (
        .clk(clk), .rst(rst), .h(h), .v(v),
        .line_end(line_end), .frame_end(frame_end), .raw(raw)
    );

    vtg_rowtrack #(
        .V_VIS(V_VIS), .WIN_H(WIN_H), .CELL_H_N(CELL_H_N), .CELL_H_W(CELL_H_W),
        .NCOL_64(NCOL_64), .NCOL_32(NCOL_32), .NCOL_80(NCOL_80),
        .VW(VW), .AW(AW)
    ) u_rows (
        .clk(clk), .rst(rst), .v(v), .line_end(line_end), .frame_end(frame_end),
        .mode(mode_q), .v_in(v_in), .row_base(row_base), .grow(grow)
    );

    vtg_fetch #(
        .H_VIS(H_VIS), .WIN_W(WIN_W), .HW(HW), .AW(AW), .CODE_W(CODE_W)
    ) u_fetch (
        .clk(clk), .rst(rst), .h(h), .mode(mode_q), .v_in(v_in),
        .row_base(row_base), .grow(grow), .raw(raw),
        .vram_data(vram_data), .font_data(font_data),
        .vram_addr(vram_addr), .font_addr(font_addr),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pixel(pixel)
    );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int H_TOT    = 800,
    parameter int H_SYNC   = 96,
    parameter int V_TOT    = 525,
    parameter int V_SYNC   = 2,
    parameter int NCELL    = 1920,
    parameter int CELL_H_N = 12,
    parameter int AW       = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          blank,
    input logic          pixel,
    input logic [AW-1:0] vram_addr,
    input logic [3:0]    font_row,
    input logic          frame_end,
    input logic [1:0]    mode_q
);
    int   hs_run;
    int   vs_run;
    int   hs_gap;
    logic hs_prev;
    logic hs_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_run  <= 0;
            vs_run  <= 0;
            hs_gap  <= 0;
            hs_prev <= 1'b1;
            hs_seen <= 1'b0;
        end else begin
            hs_run  <= hsync_n ? 0 : hs_run + 1;
            vs_run  <= vsync_n ? 0 : vs_run + 1;
            hs_prev <= hsync_n;
            if (hs_prev && !hsync_n) begin
                hs_gap  <= 1;
                hs_seen <= 1'b1;
            end else begin
                hs_gap <= hs_gap + 1;
            end
        end
    end

    AST_HS_LOW_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (hs_run == H_SYNC)); // R1
    AST_HS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ($fell(hsync_n) && hs_seen) |-> (hs_gap == H_TOT)); // R1
    AST_VS_LOW_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (vs_run == V_SYNC * H_TOT)); // R2
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pixel); // R3
    AST_CELL_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(vram_addr) < NCELL); // R6
    AST_GLYPH_ROW: assert property (@(posedge clk) disable iff (rst)
        int'(font_row) < CELL_H_N); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(frame_end)); // R10
endmodule

bind vga_text_gen vtg_checker #(
    .H_TOT(H_TOT), .H_SYNC(H_SYNC), .V_TOT(V_TOT), .V_SYNC(V_SYNC),
    .NCELL((V_VIS / (2 * CELL_H_W)) * NCOL_80), .CELL_H_N(CELL_H_N), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .pixel(pixel), .vram_addr(vram_addr),
    .font_row(font_addr[3:0]), .frame_end(frame_end), .mode_q(mode_q)
);

// File: tb/vga_text_gen_tb.sv
module vga_text_gen_tb;
    localparam int H_VIS = 96, H_FP = 4, H_SYNC = 8, H_BP = 4;
    localparam int V_VIS = 60, V_FP = 2, V_SYNC = 2, V_BP = 3;
    localparam int WIN_W = 64, WIN_H = 48;
    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int FT    = H_TOT * V_TOT;
    localparam int HOFF  = (H_VIS - WIN_W) / 2;
    localparam int VOFF  = (V_VIS - WIN_H) / 2;
    localparam int LAT   = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [10:0] vram_addr;
    logic [7:0]  vram_data = '0;
    logic [11:0] font_addr;
    logic [7:0]  font_data = '0;
    logic        hsync_n, vsync_n, blank, pixel;

    int          edges;
    logic [1:0]  fmode [0:15];
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    vga_text_gen #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .WIN_W(WIN_W), .WIN_H(WIN_H)
    ) u_dut (
        .clk(clk), .rst(rst), .mode(mode),
        .vram_addr(vram_addr), .vram_data(vram_data),
        .font_addr(font_addr), .font_data(font_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pixel(pixel)
    );

    function automatic logic [7:0] vram_fn(input int a);
        return 8'((a * 13 + 7) ^ (a >> 2));
    endfunction

    function automatic logic [7:0] font_fn(input int a);
        return 8'((a * 53) + (a >> 5) + 11);
    endfunction

    // one-clock synchronous memories (R9)
    always @(posedge clk) begin
        vram_data <= vram_fn(int'(vram_addr));
        font_data <= font_fn(int'(font_addr));
    end

    // edge counter and per-frame mode record (R10)
    always @(posedge clk) begin
        if (rst) begin
            edges     <= 0;
            fmode[0]  <= mode;
        end else begin
            edges <= edges + 1;
            if (((edges + 1) % FT) == 0 && ((edges + 1) / FT) < 16)
                fmode[(edges + 1) / FT] <= mode;
        end
    end

    task automatic cmp(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at edge %0d: actual %b expected %b", tag, what, edges, act, exp);
        end
    endtask

    task automatic check_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            logic ehs, evs, ebl, epx;
            string ptag;
            @(negedge clk);
            if (edges < LAT) begin
                ehs = 1; evs = 1; ebl = 1; epx = 0; ptag = "R9,R11";
            end else begin
                int p, h, v, x, y, gl, ch, cols, row, gr, col, b, code;
                logic [1:0] md;
                logic inwin;
                logic [7:0] gbyte;
                p  = edges - LAT;
                md = fmode[(p / FT) % 16];
                h  = p % H_TOT;
                v  = (p / H_TOT) % V_TOT;
                ehs = !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC);
                evs = !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC);
                ebl = !(h < H_VIS && v < V_VIS);
                epx = 0;
                if (md[1]) begin
                    inwin = !ebl; x = h; y = v; cols = H_VIS / 8; ch = 10;
                    ptag = "R6,R7,R8";
                end else begin
                    inwin = (h >= HOFF && h < HOFF + WIN_W && v >= VOFF && v < VOFF + WIN_H);
                    x = h - HOFF; y = v - VOFF; ch = 12;
                    cols = md[0] ? WIN_W / 16 : WIN_W / 8;
                    ptag = md[0] ? "R5,R7,R8" : "R4,R7,R8";
                end
                if (inwin) begin
                    gl   = y / 2;
                    row  = gl / ch;
                    gr   = gl % ch;
                    col  = (!md[1] && md[0]) ? x / 16 : x / 8;
                    b    = (!md[1] && md[0]) ? (x / 2) % 8 : x % 8;
                    code = int'(vram_fn(row * cols + col));
                    gbyte = font_fn(code * 16 + gr);
                    epx  = gbyte[7 - b];
                end
            end
            cmp(hsync_n, ehs, "R1", "hsync_n");
            cmp(vsync_n, evs, "R2", "vsync_n");
            cmp(blank,   ebl, "R3", "blank");
            cmp(pixel,   epx, ptag, "pixel");
        end
    endtask

    // R11: idle outputs in reset, then R9 pipeline fill
    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cmp(hsync_n, 1'b1, "R11", "hsync_n in reset");
            cmp(vsync_n, 1'b1, "R11", "vsync_n in reset");
            cmp(blank,   1'b1, "R11", "blank in reset");
            cmp(pixel,   1'b0, "R11", "pixel in reset");
        end
        rst = 1'b0;
        check_cycles(40);
    endtask

    // one layout for a full frame: R4 / R5 / R6 depending on sel
    task automatic t_layout(input logic [1:0] sel);
        @(negedge clk);
        mode = sel;
        check_cycles(FT - (edges % FT));
        check_cycles(FT);
    endtask

    // R10: change in mid-frame must not disturb the running frame
    task automatic t_mid_switch();
        check_cycles(FT / 2 - (edges % FT) + FT);
        mode = 2'b01;
        check_cycles(FT / 4);
        mode = 2'b00;
        check_cycles(FT - (edges % FT));
        check_cycles(FT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_layout(2'b00);   // R4
        t_layout(2'b01);   // R5
        t_layout(2'b10);   // R6
        t_layout(2'b11);   // R6 alias encoding
        t_mid_switch();    // R10
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule